// File: doc/BRIEF.md
# Mask-Steered Bit Scatter/Gather Unit

This block rearranges the bits of one data word under the control of a mask word of the same width. It supports four operations. Scatter spreads the low data bits out to the positions the mask marks. Gather collects the marked data bits into the low end of the result. Partition collects the marked bits at the bottom and stacks the unmarked bits directly above them. The fourth operation copies the data through unchanged. In every case, bits of one class keep their relative order.

Each bit's destination is computed as a population count of the mask bits below it. That count comes from a single prefix-count network, and all three permutations share it. The permutation itself is combinational. The result and a valid flag are captured in one register stage, so a request presented with `in_valid` appears on the outputs exactly one clock later. With no request, the result register keeps its value. The width `W` may be 8, 16, 32 or 64; any other value stops elaboration.

Top module: `bitperm_unit`

## Requirements
- R1: Operation code 2'b00 (scatter): walking result positions upward from bit 0, each position whose mask bit is 1 receives the next data bit, starting with data bit 0. Every result bit whose mask bit is 0 is 0.
- R2: Operation code 2'b01 (gather): walking data positions upward from bit 0, each data bit whose mask bit is 1 fills the next free result position, starting at result bit 0. Result bits above the last filled position are 0.
- R3: Operation code 2'b10 (partition): the mask-selected data bits fill the low result positions in ascending order. The unselected data bits fill the positions directly above them, also in ascending order. No result bit is left undefined.
- R4: Operation code 2'b11 returns the data word unchanged.
- R5: With an all-zero mask, scatter and gather return 0 and partition returns the data unchanged.
- R6: With an all-ones mask, scatter, gather and partition each return the data unchanged.
- R7: `out_valid` equals `in_valid` from the previous clock. Each accepted request produces exactly one valid result, in request order.
- R8: A synchronous active-high `rst` clears `out_valid` and `result` at the next clock edge. This holds even when `in_valid` is high in the same cycle, and that request is discarded.
- R9: In a cycle where `in_valid` is low, `result` keeps its previous value.
- R10: Order is preserved within each class. A lower-indexed source bit never lands above a higher-indexed source bit that was routed the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation: 00 scatter, 01 gather, 10 partition, 11 pass |
| data_in | input | W | Data word to rearrange |
| mask_in | input | W | Mask word steering the rearrangement |
| out_valid | output | 1 | High for one cycle per accepted request |
| result | output | W | Registered rearranged word |

## Verification
Two events can arrive at the output register in the same cycle: a new request loading its result, and the synchronous reset clearing that register. The bench provokes this by raising `rst` and `in_valid` on the same clock, with a non-zero expected result that would otherwise appear. It judges the outcome from the next cycle: `out_valid` and `result` must both be zero, and no extra item may reach the scoreboard. The competition between loading and holding is also judged: after idle gaps of random length, `result` must keep the last delivered value.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

   typedef enum logic [1:0] {
      OP_SCATTER = 2'b00,
      OP_GATHER  = 2'b01,
      OP_PART    = 2'b10,
      OP_PASS    = 2'b11
   } perm_op_e;

   function automatic bit width_supported(input int w);
      return (w == 8) || (w == 16) || (w == 32) || (w == 64);
   endfunction

endpackage

// File: rtl/bitperm_rank.sv
// Exclusive prefix population count of the mask: rank_o[i] is the number of
// ones in mask_i[i-1:0]; total_o is the count over the whole word.
module bitperm_rank #(
   parameter int W  = 32,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]          mask_i,
   output logic [W-1:0][CW-1:0]  rank_o,
   output logic [CW-1:0]         total_o
);

   always_comb begin
      logic [CW-1:0] run;
      run = '0;
      for (int i = 0; i < W; i++) begin
         rank_o[i] = run;
         run       = run + CW'(mask_i[i]);
      end
      total_o = run;
   end

endmodule

// File: rtl/bitperm_compress.sv
// Routes each enabled source bit to its destination index; positions that
// receive no bit read as 0. Shared by gather and partition.
module bitperm_compress #(
   parameter int W  = 32,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]          data_i,
   input  logic [W-1:0]          en_i,
   input  logic [W-1:0][CW-1:0]  dest_i,
   output logic [W-1:0]          res_o
);

   always_comb begin
      res_o = '0;
      for (int j = 0; j < W; j++) begin
         for (int i = 0; i < W; i++) begin
            if (en_i[i] && (dest_i[i] == CW'(j))) begin
               res_o[j] = res_o[j] | data_i[i];
            end
         end
      end
   end

endmodule

// File: rtl/bitperm_expand.sv
// Scatter: result bit j takes data bit rank[j] where the mask is set.
module bitperm_expand #(
   parameter int W  = 32,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]          data_i,
   input  logic [W-1:0]          mask_i,
   input  logic [W-1:0][CW-1:0]  rank_i,
   output logic [W-1:0]          res_o
);

   always_comb begin
      res_o = '0;
      for (int j = 0; j < W; j++) begin
         for (int k = 0; k < W; k++) begin
            if (mask_i[j] && (rank_i[j] == CW'(k))) begin
               res_o[j] = data_i[k];
            end
         end
      end
   end

endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit #(
   parameter int W = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [1:0]    op_sel,
   input  logic [W-1:0]  data_in,
   input  logic [W-1:0]  mask_in,
   output logic          out_valid,
   output logic [W-1:0]  result
);
   import bitperm_pkg::*;

   localparam int CW = $clog2(W + 1);

   generate
      if (!width_supported(W)) begin : g_bad_width
         $error("bitperm_unit: W must be 8, 16, 32 or 64");
      end
   endgenerate

   perm_op_e                op;
   logic [W-1:0][CW-1:0]    rank1;
   logic [CW-1:0]           total1;
   logic [W-1:0][CW-1:0]    part_dest;
   logic [W-1:0][CW-1:0]    cmp_dest;
   logic [W-1:0]            cmp_en;
   logic [W-1:0]            cmp_res;
   logic [W-1:0]            exp_res;
   logic [W-1:0]            next_res;

   assign op = perm_op_e'(op_sel);

   bitperm_rank #(.W(W), .CW(CW)) u_rank (
      .mask_i  (mask_in),
      .rank_o  (rank1),
      .total_o (total1)
   );

   // Partition: selected bits go to their rank, the rest stack above the
   // selected group at total + (number of zeros below them).
   always_comb begin
      for (int i = 0; i < W; i++) begin
         if (mask_in[i]) part_dest[i] = rank1[i];
         else            part_dest[i] = total1 + (CW'(i) - rank1[i]);
      end
   end

   assign cmp_en   = (op == OP_PART) ? '1 : mask_in;
   assign cmp_dest = (op == OP_PART) ? part_dest : rank1;

   bitperm_compress #(.W(W), .CW(CW)) u_compress (
      .data_i (data_in),
      .en_i   (cmp_en),
      .dest_i (cmp_dest),
      .res_o  (cmp_res)
   );

   bitperm_expand #(.W(W), .CW(CW)) u_expand (
      .data_i (data_in),
      .mask_i (mask_in),
      .rank_i (rank1),
      .res_o  (exp_res)
   );

   always_comb begin
      unique case (op)
         OP_SCATTER: next_res = exp_res;
         OP_GATHER,
         OP_PART:    next_res = cmp_res;
         default:    next_res = data_in;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end

endmodule

// File: rtl/bitperm_unit_chk.sv
module bitperm_unit_chk #(
   parameter int W = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [1:0]    op_sel,
   input logic [W-1:0]  data_in,
   input logic [W-1:0]  mask_in,
   input logic          out_valid,
   input logic [W-1:0]  result
);

   // R8
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && result == '0));

   // R7
   valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(in_valid)) |-> $stable(result));

   // R4
   pass_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && $past(op_sel) == 2'b11)
      |-> (result == $past(data_in)));

   // R1
   scatter_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && $past(op_sel) == 2'b00)
      |-> ((result & ~$past(mask_in)) == '0));

   // R2
   gather_ones_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && $past(op_sel) == 2'b01)
      |-> ($countones(result) == $countones($past(data_in & mask_in))));

   // R3
   part_ones_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && $past(op_sel) == 2'b10)
      |-> ($countones(result) == $countones($past(data_in))));

   // R5
   zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && !$past(op_sel[1]) && $past(mask_in) == '0)
      |-> (result == '0));

   // R6
   ones_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && $past(mask_in) == '1)
      |-> (result == $past(data_in)));

endmodule

bind bitperm_unit bitperm_unit_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .op_sel    (op_sel),
   .data_in   (data_in),
   .mask_in   (mask_in),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/bitperm_unit_test.sv
`timescale 1ns/1ps
module bitperm_unit_test;
   localparam int W = 32;

   typedef struct {
      logic [W-1:0] exp;
      string        req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [1:0]    op_sel = 2'b00;
   logic [W-1:0]  data_in = '0;
   logic [W-1:0]  mask_in = '0;
   logic          out_valid;
   logic [W-1:0]  result;

   int     checks = 0;
   int     fails  = 0;
   item_t  sb[$];
   logic [W-1:0] last_res = '0;

   always #2.5 clk = ~clk;

   bitperm_unit #(.W(W)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
      .data_in(data_in), .mask_in(mask_in),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [W-1:0] ref_model(input logic [1:0] op,
                                              input logic [W-1:0] d,
                                              input logic [W-1:0] m);
      logic [W-1:0] r;
      int k;
      r = '0;
      k = 0;
      case (op)
         2'b00: for (int p = 0; p < W; p++) if (m[p]) begin r[p] = d[k]; k++; end
         2'b01: for (int p = 0; p < W; p++) if (m[p]) begin r[k] = d[p]; k++; end
         2'b10: begin
            for (int p = 0; p < W; p++) if (m[p])  begin r[k] = d[p]; k++; end
            for (int p = 0; p < W; p++) if (!m[p]) begin r[k] = d[p]; k++; end
         end
         default: r = d;
      endcase
      return r;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] op, input logic [W-1:0] d,
                       input logic [W-1:0] m, input string req);
      item_t it;
      it.exp = ref_model(op, d, m);
      it.req = req;
      sb.push_back(it);
      op_sel = op; data_in = d; mask_in = m; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor: samples just after each rising edge.
   always @(posedge clk) begin
      #1;
      if (rst) begin
         check(!out_valid && result == '0, "R8", result, '0);
         last_res = '0;
      end else if (out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected valid", result, last_res);
         end else begin
            item_t it;
            it = sb.pop_front();
            check(result === it.exp, it.req, result, it.exp);
            last_res = it.exp;
         end
      end else begin
         check(result === last_res, "R9", result, last_res);
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      check(1'b0, "R7 watchdog", result, '0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 scatter corners
      send(2'b00, 32'hFFFF_FFFF, 32'h0F0F_00F0, "R1");
      send(2'b00, 32'h0000_00A5, 32'h8421_8421, "R1");
      // R2 gather corners, R10 order
      send(2'b01, 32'hDEAD_BEEF, 32'hFF00_0000, "R2");
      send(2'b01, 32'h0000_00B4, 32'h0000_00F0, "R10 gather order");
      // R3 partition, R10 order
      send(2'b10, 32'h0000_000D, 32'h0000_0005, "R3");
      send(2'b10, 32'h1234_5678, 32'hAAAA_AAAA, "R10 partition order");
      // R4 pass
      send(2'b11, 32'hCAFE_F00D, 32'h1357_9BDF, "R4");
      // R5 zero mask
      send(2'b00, 32'h5A5A_5A5A, 32'h0, "R5 scatter");
      send(2'b01, 32'h5A5A_5A5A, 32'h0, "R5 gather");
      send(2'b10, 32'h5A5A_5A5A, 32'h0, "R5 partition");
      // R6 ones mask
      send(2'b00, 32'h9876_5432, 32'hFFFF_FFFF, "R6 scatter");
      send(2'b01, 32'h9876_5432, 32'hFFFF_FFFF, "R6 gather");
      send(2'b10, 32'h9876_5432, 32'hFFFF_FFFF, "R6 partition");
      repeat (3) @(negedge clk);   // R9 idle hold
      // Random traffic with gaps (R1, R2, R3, R4, R7, R9)
      for (int n = 0; n < 400; n++) begin
         logic [1:0] op;
         string tg;
         op = 2'($urandom_range(0, 3));
         tg = (op == 2'b00) ? "R1 rand" : (op == 2'b01) ? "R2 rand" :
              (op == 2'b10) ? "R3 rand" : "R4 rand";
         send(op, $urandom, $urandom, tg);
         if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R7 drain", W'(sb.size()), '0);
      // R8: reset collides with a request; request must be dropped
      rst = 1'b1; in_valid = 1'b1;
      op_sel = 2'b11; data_in = 32'hFFFF_0001; mask_in = '0;
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b0;
      @(negedge clk);
      check(!out_valid && result == '0 && sb.size() == 0, "R8 collision", result, '0);
      send(2'b10, 32'h0F0F_0F0F, 32'h3333_3333, "R3 after reset");
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R7 final drain", W'(sb.size()), '0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule